// File: doc/BRIEF.md
# Multi-Master Bus Arbiter with Locked Sequences

This block decides which bus master drives the shared address and control lines of a pipelined system bus. Each real master raises a request line and, for indivisible sequences, a lock line. The arbiter returns a one-hot grant vector, the index of the master that owns the current address phase, and a flag that marks that address phase as locked. Slot 0 is kept for a dummy master that never transfers anything. Slot 0 is granted when no real master may be given the bus. A default master, chosen by parameter, receives the grant when nobody asks.

The arbiter watches the transfer type, burst kind, ready and response lines of the bus. It keeps the grant on a master that has started a fixed-length burst, and it picks again on every cycle during undefined-length bursts. It holds the bus for a locking master and grants one unlocked transfer after the lock drops. It handles retried and split responses to the last locked transfer. A master that has been split is kept out of arbitration until it lowers its request.

Top module: `bus_arbiter`

## Requirements
- R1: During and right after reset, the grant selects the default slot (parameter, default 3), the owner index equals that slot, and the locked flag is low.
- R2: Exactly one grant bit is high in every cycle. A request on slot 0 never wins arbitration.
- R3: With no hold active, the grant goes to the lowest-numbered real master whose request is high and which is not excluded.
- R4: If no eligible master requests, the default slot is granted. If the default slot is excluded, slot 0 is granted instead.
- R5: The owner index changes only at a clock edge where ready is high, and it then takes the index that was granted during that cycle.
- R6: A first beat (type code 2) of a fixed-length burst (burst codes 2/3 = 4 beats, 4/5 = 8, 6/7 = 16), accepted while the grant already points at the owner, holds the grant on the owner. The grant may move at the edge that accepts beat L-1, so ownership passes right after beat L.
- R7: A single transfer (burst code 0) or an undefined-length burst (burst code 1) holds nothing, and arbitration runs on every cycle.
- R8: A response other than OKAY (codes: OKAY 0, ERROR 1, RETRY 2, SPLIT 3) clears any burst hold in the cycle it appears.
- R9: While the lock input of the owning real master is high, the grant stays on that master. At each ready-high edge the locked flag takes the lock input of the master taking ownership.
- R10: After the lock input drops, the locking master owns exactly one more address phase, with the locked flag low, before ownership moves.
- R11: A RETRY response in the data phase of a locked transfer puts the grant back on the master that issued it.
- R12: A SPLIT response in the data phase of a locked transfer moves the grant to slot 0.
- R13: A master that receives SPLIT is excluded until its request goes low. When every real master is excluded, slot 0 is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | NUM_SLOTS | Request per slot (slot 0 ignored) |
| bus_lock | input | NUM_SLOTS | Lock request per slot (slot 0 ignored) |
| xfer_type | input | 2 | Transfer type of current address phase: 0 idle, 1 busy, 2 first beat, 3 following beat |
| burst_kind | input | 3 | Burst kind of current address phase |
| ready_in | input | 1 | Bus ready; high ends the current data phase |
| resp_in | input | 2 | Slave response of current data phase |
| grant_out | output | NUM_SLOTS | Registered one-hot grant |
| owner_id | output | $clog2(NUM_SLOTS) | Slot index owning the current address phase |
| owner_locked | output | 1 | Current address phase is part of a locked sequence |

## Verification
A stale beat counter shows at the grant port as a hand-over that comes one or more beats too early or too late. The tests make this visible within the burst by putting a higher-priority request against the owner. A wrong lock or data-phase lock register shows either as a missing extra transfer or as the grant not jumping to the locker or to slot 0 one edge after a RETRY or SPLIT. A stuck exclusion bit keeps a master away from the grant after it has dropped and raised its request again. That shows up in the first cycle after the request comes back.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam logic [1:0] TR_IDLE = 2'd0;
  localparam logic [1:0] TR_BUSY = 2'd1;
  localparam logic [1:0] TR_NSEQ = 2'd2;
  localparam logic [1:0] TR_SEQ  = 2'd3;

  localparam logic [1:0] RSP_OKAY  = 2'd0;
  localparam logic [1:0] RSP_ERROR = 2'd1;
  localparam logic [1:0] RSP_RETRY = 2'd2;
  localparam logic [1:0] RSP_SPLIT = 2'd3;

  // beats in a fixed-length burst, zero for single or open-ended kinds
  function automatic logic [4:0] burst_len(input logic [2:0] kind);
    case (kind)
      3'd2, 3'd3: burst_len = 5'd4;
      3'd4, 3'd5: burst_len = 5'd8;
      3'd6, 3'd7: burst_len = 5'd16;
      default:    burst_len = 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/beat_tracker.sv
module beat_tracker
  import arb_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ready_in,
  input  logic [1:0] xfer_type,
  input  logic [2:0] burst_kind,
  input  logic [1:0] resp_in,
  input  logic       same_owner,
  output logic       hold
);
  logic [CW-1:0] left_q, left_nx;
  logic [4:0]    len;

  always_comb begin
    len     = burst_len(burst_kind);
    left_nx = left_q;
    if (ready_in) begin
      if (xfer_type == TR_NSEQ)
        left_nx = (len != 5'd0 && same_owner) ? CW'(len - 5'd1) : '0;
      else if (xfer_type == TR_SEQ && left_q != '0)
        left_nx = left_q - CW'(1);
      else if (xfer_type == TR_IDLE)
        left_nx = '0;
    end
    if (resp_in != RSP_OKAY) left_nx = '0;
  end

  assign hold = (left_nx > CW'(1));

  always_ff @(posedge clk) begin
    if (rst) left_q <= '0;
    else     left_q <= left_nx;
  end
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  cand,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_SLOTS    = 4,
  parameter int DEFAULT_SLOT = 3,
  parameter int MAX_BEATS    = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_SLOTS-1:0]         bus_req,
  input  logic [NUM_SLOTS-1:0]         bus_lock,
  input  logic [1:0]                   xfer_type,
  input  logic [2:0]                   burst_kind,
  input  logic                         ready_in,
  input  logic [1:0]                   resp_in,
  output logic [NUM_SLOTS-1:0]         grant_out,
  output logic [$clog2(NUM_SLOTS)-1:0] owner_id,
  output logic                         owner_locked
);
  localparam int IW = $clog2(NUM_SLOTS);
  localparam int CW = $clog2(MAX_BEATS);
  localparam logic [NUM_SLOTS-1:0] ONE  = NUM_SLOTS'(1);
  localparam logic [NUM_SLOTS-1:0] REAL = ~ONE;
  localparam logic [IW-1:0] DEF = IW'(DEFAULT_SLOT);

  logic [IW-1:0]        gidx_q, own_q, downer_q, nxt, pick;
  logic [NUM_SLOTS-1:0] grant_q, split_q, split_nx, cand;
  logic                 olock_q, dlock_q, found, burst_hold, lock_hold, same_owner;

  assign same_owner = (gidx_q == own_q);
  assign lock_hold  = (own_q != '0) && bus_lock[own_q];
  assign cand       = bus_req & REAL & ~split_q;
  assign split_nx   = (split_q & bus_req) |
                      ((resp_in == RSP_SPLIT) ? (ONE << downer_q) : '0);

  beat_tracker #(.CW(CW)) u_beats (
    .clk(clk), .rst(rst), .ready_in(ready_in), .xfer_type(xfer_type),
    .burst_kind(burst_kind), .resp_in(resp_in), .same_owner(same_owner),
    .hold(burst_hold)
  );

  prio_pick #(.N(NUM_SLOTS), .IW(IW)) u_pick (
    .cand(cand), .found(found), .idx(pick)
  );

  always_comb begin
    if (dlock_q && resp_in == RSP_SPLIT)      nxt = '0;
    else if (dlock_q && resp_in == RSP_RETRY) nxt = downer_q;
    else if (burst_hold || lock_hold)         nxt = own_q;
    else if (found)                           nxt = pick;
    else if (!split_q[DEF])                   nxt = DEF;
    else                                      nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gidx_q   <= DEF;
      grant_q  <= ONE << DEF;
      own_q    <= DEF;
      downer_q <= DEF;
      olock_q  <= 1'b0;
      dlock_q  <= 1'b0;
      split_q  <= '0;
    end else begin
      gidx_q  <= nxt;
      grant_q <= ONE << nxt;
      split_q <= split_nx;
      if (ready_in) begin
        own_q    <= gidx_q;
        olock_q  <= (gidx_q != '0) && bus_lock[gidx_q];
        dlock_q  <= olock_q;
        downer_q <= own_q;
      end
    end
  end

  assign grant_out    = grant_q;
  assign owner_id     = own_q;
  assign owner_locked = olock_q;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int NUM_SLOTS = 4
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NUM_SLOTS-1:0]         bus_lock,
  input logic                         ready_in,
  input logic [1:0]                   resp_in,
  input logic [NUM_SLOTS-1:0]         grant_out,
  input logic [$clog2(NUM_SLOTS)-1:0] owner_id,
  input logic                         owner_locked
);
  logic [NUM_SLOTS-1:0]         g_d;
  logic [$clog2(NUM_SLOTS)-1:0] o_d;
  logic                         dl;

  always_ff @(posedge clk) begin
    if (rst) begin
      g_d <= '0;
      o_d <= '0;
      dl  <= 1'b0;
    end else begin
      g_d <= grant_out;
      o_d <= owner_id;
      if (ready_in) dl <= owner_locked;
    end
  end

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(grant_out) == 1);

  assert_owner_stable_R5: assert property (@(posedge clk) disable iff (rst)
    !ready_in |=> $stable(owner_id));

  assert_owner_follows_R5: assert property (@(posedge clk) disable iff (rst)
    ready_in |=> g_d[owner_id]);

  assert_lock_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (owner_id != '0 && bus_lock[owner_id] &&
     !(dl && (resp_in == 2'd2 || resp_in == 2'd3))) |=> grant_out[o_d]);

  assert_lock_not_dummy_R9: assert property (@(posedge clk) disable iff (rst)
    owner_locked |-> owner_id != '0);

  assert_split_dummy_R12: assert property (@(posedge clk) disable iff (rst)
    (dl && resp_in == 2'd3) |=> grant_out[0]);
endmodule

bind bus_arbiter arb_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst(rst), .bus_lock(bus_lock), .ready_in(ready_in),
  .resp_in(resp_in), .grant_out(grant_out), .owner_id(owner_id),
  .owner_locked(owner_locked)
);

// File: tb/sim_bus_arbiter.sv
module sim_bus_arbiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] req = '0, lck = '0;
  logic [1:0] trans = 2'd0, resp = 2'd0;
  logic [2:0] burst = 3'd0;
  logic       ready = 1'b1;
  logic [3:0] grant;
  logic [1:0] owner;
  logic       olock;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_arbiter u0 (
    .clk(clk), .rst(rst), .bus_req(req), .bus_lock(lck), .xfer_type(trans),
    .burst_kind(burst), .ready_in(ready), .resp_in(resp),
    .grant_out(grant), .owner_id(owner), .owner_locked(olock)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle_in();
    req = '0; lck = '0; trans = 2'd0; burst = 3'd0; ready = 1'b1; resp = 2'd0;
  endtask

  task automatic do_reset();
    idle_in();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
  endtask

  task automatic claim(input int m);
    req = 4'(1 << m);
    step(); step();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 grant", grant, 4'b1000);
    chk("R1 owner", owner, 3);
    chk("R1 locked", olock, 0);
  endtask

  task automatic t_priority();
    do_reset();
    req = 4'b1110; step();
    chk("R3 lowest index wins", grant, 4'b0010);
    chk("R5 owner takes old grant", owner, 3);
    step();
    chk("R5 owner follows grant", owner, 1);
    req = 4'b0001; step();
    chk("R2 slot0 request ignored", grant, 4'b1000);
    req = 4'b0000; step();
    chk("R4 default when idle", grant, 4'b1000);
  endtask

  task automatic t_ready();
    do_reset();
    req = 4'b0100; ready = 1'b0; step();
    chk("R5 grant moves", grant, 4'b0100);
    chk("R5 owner held low ready", owner, 3);
    step();
    chk("R5 owner held low ready 2", owner, 3);
    ready = 1'b1; step();
    chk("R5 owner on ready", owner, 2);
  endtask

  task automatic t_fixed4();
    do_reset(); claim(2);
    req = 4'b0010; trans = 2'd2; burst = 3'd3; step();
    chk("R6 hold after first beat", grant, 4'b0100);
    trans = 2'd3; step();
    chk("R6 hold beat2", grant, 4'b0100);
    step();
    chk("R6 release at beat3", grant, 4'b0010);
    chk("R6 owner through beat4", owner, 2);
    step();
    chk("R6 owner passes after beat4", owner, 1);
  endtask

  task automatic t_fixed8();
    do_reset(); claim(2);
    req = 4'b0010; trans = 2'd2; burst = 3'd4; step();
    trans = 2'd3;
    for (int i = 0; i < 5; i++) step();
    chk("R6 wrap8 hold through beat6", grant, 4'b0100);
    step();
    chk("R6 wrap8 release at beat7", grant, 4'b0010);
  endtask

  task automatic t_incr();
    do_reset(); claim(2);
    req = 4'b0110; trans = 2'd2; burst = 3'd1; step();
    chk("R7 open burst rearbitrated", grant, 4'b0010);
  endtask

  task automatic t_error();
    do_reset(); claim(2);
    req = 4'b0110; trans = 2'd2; burst = 3'd5; step();
    chk("R6 incr8 held", grant, 4'b0100);
    trans = 2'd3; resp = 2'd1; ready = 1'b0; step();
    chk("R8 error ends hold", grant, 4'b0010);
  endtask

  task automatic lock_prefix();
    do_reset(); claim(2);
    req = 4'b0110; lck = 4'b0100; trans = 2'd0; step();
    chk("R9 locked flag", olock, 1);
    chk("R9 grant held by lock", grant, 4'b0100);
    trans = 2'd2; burst = 3'd0; step();
    chk("R9 grant held locked beat", grant, 4'b0100);
    lck = 4'b0000; step();
  endtask

  task automatic t_lock();
    lock_prefix();
    chk("R10 grant moves after lock", grant, 4'b0010);
    chk("R10 extra transfer owner", owner, 2);
    chk("R10 extra transfer unlocked", olock, 0);
    trans = 2'd0; step();
    chk("R10 owner moves after extra", owner, 1);
  endtask

  task automatic t_lock_retry();
    lock_prefix();
    trans = 2'd0; resp = 2'd2; ready = 1'b0; step();
    chk("R11 retry regrants locker", grant, 4'b0100);
    ready = 1'b1; step();
    chk("R11 retry grant kept", grant, 4'b0100);
    chk("R11 retry owner", owner, 2);
  endtask

  task automatic t_lock_split();
    lock_prefix();
    trans = 2'd0; resp = 2'd3; ready = 1'b0; step();
    chk("R12 split grants dummy", grant, 4'b0001);
    ready = 1'b1; step();
    chk("R12 owner dummy", owner, 0);
    resp = 2'd0; req = 4'b0100; step();
    chk("R13 split master excluded", grant, 4'b1000);
  endtask

  task automatic t_all_split();
    do_reset();
    req = 4'b1110; resp = 2'd3;
    for (int i = 0; i < 12; i++) step();
    resp = 2'd0; step();
    chk("R13 all split dummy", grant, 4'b0001);
    chk("R13 all split owner", owner, 0);
    req = 4'b1010; step();
    chk("R13 still dummy", grant, 4'b0001);
    req = 4'b1110; step();
    chk("R13 readmitted after drop", grant, 4'b0100);
  endtask

  initial begin
    step();
    t_reset();
    t_priority();
    t_ready();
    t_fixed4();
    t_fixed8();
    t_incr();
    t_error();
    t_lock();
    t_lock_retry();
    t_lock_split();
    t_all_split();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule